// File: doc/BRIEF.md
# UART FIFO control and trigger logic

This block is the FIFO control register of a 16550-style UART, together with the receive and transmit byte queues that the register governs. The CPU writes one control byte. That byte switches queued operation on or off, selects the receive interrupt threshold, and selects the DMA signalling mode. It also carries two command bits that empty either queue. The control byte is write-only: no read path for it exists.

The receive queue is loaded from a byte-valid strobe and emptied by the CPU. The transmit queue is loaded by the CPU and drained by a pop strobe from the serializer. Occupancy counts and head-of-queue bytes are visible at the ports.

A receive interrupt is raised while receive occupancy is at or above the selected threshold. With queued operation off, each direction collapses to a single-byte holding register.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, both counts are 0, and `rx_irq`, `rx_overrun`, `fifo_mode` and `dma_mode` are all low.
- R2: With `fifo_mode` high, each queue holds up to 16 bytes and returns them in arrival order. A receive push while the receive queue holds 16 bytes is dropped and sets the sticky flag `rx_overrun`. A transmit push while full is dropped.
- R3: The threshold is chosen by control bits [7:6]: code 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. `rx_irq` is high exactly while `rx_count` is at or above the threshold.
- R4: `rx_irq` falls in the same cycle that `rx_count` first shows a value below the threshold.
- R5: A write with bits 0 and 1 set empties the receive queue and clears `rx_overrun`. A write with bits 0 and 2 set empties the transmit queue. Neither command is stored, so a later write without the bit empties nothing.
- R6: `dma_mode` is high only while bit 3 of the last write is 1 and `fifo_mode` is high.
- R7: A write with bit 0 at 0 clears `fifo_mode` and leaves the stored threshold and DMA bit unchanged. In that state each queue holds one byte, `rx_irq` follows one byte present, and `dma_mode` is low.
- R8: Control bits [5:4] have no effect on any output.
- R9: A pop of an empty queue is ignored, and its count stays 0.
- R10: A write that changes bit 0 relative to the current `fifo_mode` empties both queues and clears `rx_overrun`.
- R11: A push and a pop in the same cycle on a full queue both take effect. The count stays at capacity and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| ctl_we | input | 1 | control byte write strobe |
| ctl_wdata | input | 8 | control byte |
| rx_push | input | 1 | received byte valid |
| rx_wdata | input | 8 | received byte |
| rx_pop | input | 1 | CPU removes head of receive queue |
| rx_rdata | output | 8 | head of receive queue |
| rx_count | output | 5 | receive occupancy |
| rx_overrun | output | 1 | sticky receive drop flag |
| rx_irq | output | 1 | receive threshold interrupt |
| tx_push | input | 1 | CPU writes a transmit byte |
| tx_wdata | input | 8 | transmit byte |
| tx_pop | input | 1 | serializer takes head of transmit queue |
| tx_rdata | output | 8 | head of transmit queue |
| tx_count | output | 5 | transmit occupancy |
| fifo_mode | output | 1 | queued operation enabled |
| dma_mode | output | 1 | DMA signalling mode 1 |

## Verification
A corrupted pointer or count shows up in the bytes that come out of a queue. It appears at `rx_rdata` or `tx_rdata` as soon as the bad entry reaches the head, and at the count ports in the cycle after the faulty update. A wrong threshold decode or a stale control bit shows up on `rx_irq` or `dma_mode` in the first cycle after the write. The bench compares every output against a queue model after each clock.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;
    localparam int unsigned QDEPTH = 16;
    localparam int unsigned CNT_W  = $clog2(QDEPTH + 1);

    typedef struct packed {
        logic       en;
        logic       dma;
        logic [1:0] trig;
    } ctl_t;

    function automatic logic [CNT_W-1:0] trig_level(input logic en, input logic [1:0] code);
        logic [CNT_W-1:0] lvl;
        if (!en) begin
            lvl = CNT_W'(1);
        end else begin
            case (code)
                2'd0:    lvl = CNT_W'(1);
                2'd1:    lvl = CNT_W'(4);
                2'd2:    lvl = CNT_W'(8);
                default: lvl = CNT_W'(14);
            endcase
        end
        return lvl;
    endfunction
endpackage

// File: rtl/uart_fcr_reg.sv
module uart_fcr_reg
    import uart_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output ctl_t       ctl,
    output logic       rx_flush,
    output logic       tx_flush
);
    localparam int unsigned B_EN = 0, B_RXC = 1, B_TXC = 2, B_DMA = 3, B_TRIG = 6;

    ctl_t ctl_d, ctl_q;
    logic mode_change;
    logic unused_rsvd;

    assign unused_rsvd = ^wdata[5:4];

    always_comb begin
        ctl_d       = ctl_q;
        mode_change = we && (wdata[B_EN] != ctl_q.en);
        rx_flush    = mode_change || (we && wdata[B_EN] && wdata[B_RXC]);
        tx_flush    = mode_change || (we && wdata[B_EN] && wdata[B_TXC]);
        if (we) begin
            ctl_d.en = wdata[B_EN];
            if (wdata[B_EN]) begin
                ctl_d.dma  = wdata[B_DMA];
                ctl_d.trig = wdata[B_TRIG +: 2];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign ctl = ctl_q;

    // R7
    hold_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !wdata[B_EN]) |=> ($stable(ctl_q.trig) && $stable(ctl_q.dma) && !ctl_q.en));
endmodule

// File: rtl/uart_byte_fifo.sv
module uart_byte_fifo
    import uart_fifo_pkg::*;
#(
    parameter int unsigned DEPTH = QDEPTH,
    parameter int unsigned DW    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [CNT_W-1:0] cap,
    input  logic             push,
    input  logic [DW-1:0]    wdata,
    input  logic             pop,
    output logic [DW-1:0]    rdata,
    output logic [CNT_W-1:0] count,
    output logic             drop
);
    localparam int unsigned PW = $clog2(DEPTH);

    typedef struct packed {
        logic [PW-1:0]    wr;
        logic [PW-1:0]    rd;
        logic [CNT_W-1:0] cnt;
    } fst_t;

    fst_t st_d, st_q;
    logic [DW-1:0] mem_q [DEPTH];
    logic pop_ok, push_ok;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        st_d    = st_q;
        pop_ok  = pop && (st_q.cnt != '0) && !flush;
        push_ok = push && !flush && ((st_q.cnt < cap) || pop_ok);
        drop    = push && !flush && !push_ok;
        if (flush) begin
            st_d = '0;
        end else begin
            if (pop_ok)  st_d.rd = nxt(st_q.rd);
            if (push_ok) st_d.wr = nxt(st_q.wr);
            st_d.cnt = st_q.cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[st_q.wr] <= wdata;
    end

    assign rdata = mem_q[st_q.rd];
    assign count = st_q.cnt;

    // R2
    within_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) st_q.cnt <= cap);
    // R9
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && st_q.cnt == '0) |=> (st_q.cnt == '0));
    // R5
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.cnt == '0));
endmodule

// File: rtl/uart_rx_trigger.sv
module uart_rx_trigger
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  ctl_t             ctl,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             rx_drop,
    input  logic             rx_flush,
    output logic             irq,
    output logic             overrun
);
    typedef struct packed {
        logic ovr;
    } tst_t;

    tst_t st_d, st_q;
    logic [CNT_W-1:0] level;

    always_comb begin
        level = trig_level(ctl.en, ctl.trig);
        irq   = (rx_count >= level);
        st_d  = st_q;
        if (rx_flush)     st_d.ovr = 1'b0;
        else if (rx_drop) st_d.ovr = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign overrun = st_q.ovr;

    // R3
    irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rx_count != '0));
    // R2
    overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_drop && !rx_flush) |=> overrun);
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
    import uart_fifo_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic [7:0]       ctl_wdata,
    input  logic             rx_push,
    input  logic [7:0]       rx_wdata,
    input  logic             rx_pop,
    output logic [7:0]       rx_rdata,
    output logic [CNT_W-1:0] rx_count,
    output logic             rx_overrun,
    output logic             rx_irq,
    input  logic             tx_push,
    input  logic [7:0]       tx_wdata,
    input  logic             tx_pop,
    output logic [7:0]       tx_rdata,
    output logic [CNT_W-1:0] tx_count,
    output logic             fifo_mode,
    output logic             dma_mode
);
    localparam int unsigned NDIR = 2;

    ctl_t             ctl;
    logic             rx_flush, tx_flush;
    logic [CNT_W-1:0] cap;
    logic             q_flush [NDIR];
    logic             q_push  [NDIR];
    logic             q_pop   [NDIR];
    logic [7:0]       q_wdata [NDIR];
    logic [7:0]       q_rdata [NDIR];
    logic [CNT_W-1:0] q_count [NDIR];
    logic             q_drop  [NDIR];

    uart_fcr_reg i_fcr (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .ctl(ctl), .rx_flush(rx_flush), .tx_flush(tx_flush)
    );

    assign cap = ctl.en ? CNT_W'(QDEPTH) : CNT_W'(1);

    assign q_flush[0] = rx_flush;  assign q_flush[1] = tx_flush;
    assign q_push[0]  = rx_push;   assign q_push[1]  = tx_push;
    assign q_pop[0]   = rx_pop;    assign q_pop[1]   = tx_pop;
    assign q_wdata[0] = rx_wdata;  assign q_wdata[1] = tx_wdata;

    for (genvar g = 0; g < NDIR; g++) begin : g_queue
        uart_byte_fifo #(.DEPTH(QDEPTH), .DW(8)) i_q (
            .clk(clk), .rst_n(rst_n), .flush(q_flush[g]), .cap(cap),
            .push(q_push[g]), .wdata(q_wdata[g]), .pop(q_pop[g]),
            .rdata(q_rdata[g]), .count(q_count[g]), .drop(q_drop[g])
        );
    end

    logic unused_tx_drop;
    assign unused_tx_drop = q_drop[1];

    uart_rx_trigger i_trig (
        .clk(clk), .rst_n(rst_n), .ctl(ctl), .rx_count(q_count[0]),
        .rx_drop(q_drop[0]), .rx_flush(rx_flush), .irq(rx_irq), .overrun(rx_overrun)
    );

    assign rx_rdata  = q_rdata[0];
    assign rx_count  = q_count[0];
    assign tx_rdata  = q_rdata[1];
    assign tx_count  = q_count[1];
    assign fifo_mode = ctl.en;
    assign dma_mode  = ctl.en && ctl.dma;

    // R6
    dma_needs_fifo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_mode |-> fifo_mode);
    // R7
    single_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> (rx_count <= CNT_W'(1) && tx_count <= CNT_W'(1)));
    // R11
    full_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_mode && rx_count == CNT_W'(QDEPTH) && rx_push && rx_pop && !ctl_we)
        |=> (rx_count == CNT_W'(QDEPTH)));
endmodule

// File: tb/test_uart_fifo_ctrl.sv
module test_uart_fifo_ctrl;
    localparam time CLK = 20ns;

    logic clk = 0, rst_n = 0;
    logic ctl_we = 0, rx_push = 0, rx_pop = 0, tx_push = 0, tx_pop = 0;
    logic [7:0] ctl_wdata = 0, rx_wdata = 0, tx_wdata = 0;
    logic [7:0] rx_rdata, tx_rdata;
    logic [4:0] rx_count, tx_count;
    logic rx_overrun, rx_irq, fifo_mode, dma_mode;

    int errors = 0, checks = 0;
    bit done = 0;

    byte unsigned rxq[$], txq[$];
    bit m_en, m_dma, m_ovr;
    bit [1:0] m_trig;

    always #(CLK/2) clk = ~clk;

    uart_fifo_ctrl i_uart_fifo_ctrl (.*);

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int lvl_of();
        if (!m_en) return 1;
        case (m_trig)
            2'd0: return 1;
            2'd1: return 4;
            2'd2: return 8;
            default: return 14;
        endcase
    endfunction

    task automatic compare_all();
        chk(rx_count, rxq.size(), "R2 rx_count");
        chk(tx_count, txq.size(), "R2 tx_count");
        if (rxq.size() > 0) chk(rx_rdata, rxq[0], "R2 rx_rdata");
        if (txq.size() > 0) chk(tx_rdata, txq[0], "R2 tx_rdata");
        chk(rx_irq, int'(rxq.size() >= lvl_of()), "R3 rx_irq");
        chk(rx_overrun, m_ovr, "R2 rx_overrun");
        chk(fifo_mode, m_en, "R7 fifo_mode");
        chk(dma_mode, m_en && m_dma, "R6 dma_mode");
    endtask

    task automatic step(input bit we, input bit [7:0] wd, input bit rp, input bit [7:0] rd,
                        input bit rpop, input bit tp, input bit [7:0] td, input bit tpop);
        int cap;
        bit rfl, tfl, pk, room;
        @(negedge clk);
        ctl_we = we; ctl_wdata = wd; rx_push = rp; rx_wdata = rd; rx_pop = rpop;
        tx_push = tp; tx_wdata = td; tx_pop = tpop;
        cap = m_en ? 16 : 1;
        rfl = we && ((wd[0] && wd[1]) || (wd[0] != m_en));
        tfl = we && ((wd[0] && wd[2]) || (wd[0] != m_en));
        if (rfl) begin
            rxq.delete(); m_ovr = 0;
        end else begin
            pk = rpop && rxq.size() > 0;
            room = rxq.size() < cap || pk;
            if (pk) void'(rxq.pop_front());
            if (rp) begin
                if (room) rxq.push_back(rd); else m_ovr = 1;
            end
        end
        if (tfl) txq.delete();
        else begin
            pk = tpop && txq.size() > 0;
            room = txq.size() < cap || pk;
            if (pk) void'(txq.pop_front());
            if (tp && room) txq.push_back(td);
        end
        if (we) begin
            m_en = wd[0];
            if (wd[0]) begin m_dma = wd[3]; m_trig = wd[7:6]; end
        end
        @(posedge clk); #1;
        ctl_we = 0; rx_push = 0; rx_pop = 0; tx_push = 0; tx_pop = 0;
        compare_all();
    endtask

    task automatic wr(input bit [7:0] wd);
        step(1, wd, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic rxin(input bit [7:0] d);
        step(0, 0, 1, d, 0, 0, 0, 0);
    endtask

    initial begin
        #(CLK * 200000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5eed);
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk(rx_count, 0, "R1 rx_count"); chk(tx_count, 0, "R1 tx_count");
        chk(rx_irq, 0, "R1 rx_irq"); chk(rx_overrun, 0, "R1 overrun");
        chk(fifo_mode, 0, "R1 fifo_mode"); chk(dma_mode, 0, "R1 dma_mode");

        // R7 single-byte mode: second byte dropped, dma bit ignored
        rxin(8'h11); rxin(8'h22);
        chk(rx_count, 1, "R7 single slot");
        chk(rx_irq, 1, "R7 irq on one byte");
        wr(8'h08);
        chk(dma_mode, 0, "R7 dma ignored while disabled");

        // R10 enabling flushes; trigger code 3 -> 14
        wr(8'hC1);
        chk(rx_count, 0, "R10 flush on enable");
        chk(rx_overrun, 0, "R10 overrun cleared");
        for (int i = 0; i < 13; i++) rxin(8'(i + 1));
        chk(rx_irq, 0, "R3 below 14");
        rxin(8'd14);
        chk(rx_irq, 1, "R3 at 14");
        step(0, 0, 0, 0, 1, 0, 0, 0);
        chk(rx_irq, 0, "R4 falls with count");
        for (int i = 0; i < 3; i++) rxin(8'(i + 50));
        chk(rx_count, 16, "R2 full");
        rxin(8'hEE);
        chk(rx_overrun, 1, "R2 overrun set");
        chk(rx_count, 16, "R2 dropped byte");
        // R11 push and pop on full
        step(0, 0, 1, 8'h77, 1, 0, 0, 0);
        chk(rx_count, 16, "R11 count held");
        // R8 reserved bits
        wr(8'hF1);
        chk(rx_count, 16, "R8 reserved no flush");
        chk(rx_irq, 1, "R8 trigger kept");
        // R5 rx reset, self-clearing
        wr(8'h43);
        chk(rx_count, 0, "R5 rx emptied"); chk(rx_overrun, 0, "R5 overrun cleared");
        rxin(8'h99);
        wr(8'h41);
        chk(rx_count, 1, "R5 command not stored");
        step(0, 0, 0, 0, 0, 1, 8'hAB, 0);
        wr(8'h45);
        chk(tx_count, 0, "R5 tx emptied"); chk(rx_count, 1, "R5 rx untouched");
        // R6 dma
        wr(8'h09);
        chk(dma_mode, 1, "R6 dma on");
        wr(8'h01);
        chk(dma_mode, 0, "R6 dma off");
        // R9 pop empty
        wr(8'h03);
        step(0, 0, 0, 0, 1, 0, 0, 1);
        chk(rx_count, 0, "R9 rx stays empty"); chk(tx_count, 0, "R9 tx stays empty");
        // trigger codes 1 and 2
        wr(8'h41);
        for (int i = 0; i < 3; i++) rxin(8'(i));
        chk(rx_irq, 0, "R3 below 4");
        rxin(8'h3);
        chk(rx_irq, 1, "R3 at 4");
        wr(8'h83);
        for (int i = 0; i < 8; i++) rxin(8'(i));
        chk(rx_irq, 1, "R3 at 8");

        // random phase
        for (int n = 0; n < 4000; n++) begin
            bit we;
            bit [7:0] wd;
            we = ($urandom % 24) == 0;
            wd = 8'($urandom);
            if (($urandom % 8) != 0) wd[0] = 1'b1;
            if (($urandom % 3) != 0) wd[2:1] = 2'b00;
            step(we, wd, ($urandom % 2) == 1, 8'($urandom), ($urandom % 3) == 0,
                 ($urandom % 2) == 1, 8'($urandom), ($urandom % 3) == 0);
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule